// File: doc/BRIEF.md
# First-Level Translation Buffer with True-LRU Refill

This block is a small, fully associative translation cache that sits in front of one access stream: either instruction fetch or data. Each lookup carries a 32-bit effective address, an address-space bit and an 8-bit process ID. Together these form a 41-bit tag. When a stored entry matches, the block returns a 36-bit real address one cycle later. The real address is the entry's real page number joined with the untranslated offset bits of the effective address. Each entry keeps its own page-size code, so the width of that offset follows the page the entry describes.

When no entry matches, the block raises a request to a shared second-level translation buffer, which serves both streams. The block then stalls its stream until the refill arrives. The refilled entry replaces the least recently used way, and the usage order counts both hits and refills. The response for the stalled lookup is then produced from the refilled entry.

A chip places one instance on the fetch side and one on the data side. The two instances share no state, so both can answer in the same clock cycle.

Top module: `utlb_l1`

## Requirements
- R1: A lookup is accepted when `lk_valid` is high and both `stall` and `inv_all` are low. If it matches a valid entry, then one cycle later `rsp_valid`=1 and `rsp_hit`=1, and `stall` stays low.
- R2: `rsp_ra[11:0]` equals `ea[11:0]`. For page-size code c (0..3), the low 12+4c bits of `rsp_ra` come from the effective address. The bits above them come from the entry's real page number. Code 0 is 4 KiB and code 3 is 16 MiB.
- R3: An entry matches only if all three of these equal the lookup's values: the address-space bit, the process ID, and every effective-address bit above the entry's offset width. A difference in any one of them is a miss.
- R4: An accepted lookup that misses produces no response. One cycle later, `stall` and `l2_req_valid` are high, with `l2_req_as`, `l2_req_pid` and `l2_req_ea` equal to the lookup. All of these hold steady until the refill.
- R5: While `stall` is high, `lk_valid` is ignored. No response is given and the request fields do not change.
- R6: `l2_fill_valid` while stalled writes the entry with `l2_fill_rpn` and `l2_fill_psz`, tagged with the pending lookup. One cycle later, `rsp_valid`=1, `rsp_hit`=0, `rsp_ra` is translated by the new entry, and `stall` is low. `l2_fill_valid` while not stalled is ignored.
- R7: A refill replaces the way used least recently, where hits and refills both count as uses. After reset or invalidation, refills fill ways in the order 0, 1, 2, 3.
- R8: `inv_all` clears every entry in one cycle and restores the reset replacement order. A lookup in the same cycle is dropped with no response. A refill in the same cycle still answers but is not kept.
- R9: After reset, `stall`, `l2_req_valid` and `rsp_valid` are low and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup strobe |
| lk_as | input | 1 | Address-space bit of lookup |
| lk_pid | input | 8 | Process ID of lookup |
| lk_ea | input | 32 | Effective address of lookup |
| stall | output | 1 | Refill outstanding, lookups blocked |
| rsp_valid | output | 1 | Translation result valid |
| rsp_hit | output | 1 | 1: served from buffer, 0: served by refill |
| rsp_ra | output | 36 | Real address |
| l2_req_valid | output | 1 | Refill request to second level |
| l2_req_as | output | 1 | Requested address-space bit |
| l2_req_pid | output | 8 | Requested process ID |
| l2_req_ea | output | 32 | Requested effective address |
| l2_fill_valid | input | 1 | Refill response strobe |
| l2_fill_rpn | input | 24 | Refilled real page number (address bits 35:12) |
| l2_fill_psz | input | 2 | Refilled page-size code |

## Verification
The bench goes after the LRU victim choice. A design that ignored hits when ordering ways would evict a page that was just used, and the next lookup of it would miss. Large pages are mixed with 4 KiB pages so that a wrong offset split would corrupt the real address, and a tag compare that masked the wrong bits would report false hits. Lookups are injected while the block is stalled and refill strobes are sent while it is idle; a design that accepted either would give a spurious response or change the pending request. Invalidation is issued together with a lookup; a design that let the lookup through would answer it, or would not restore the fill order.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int EA_W     = 32;
  localparam int RA_W     = 36;
  localparam int PID_W    = 8;
  localparam int OFF_MIN  = 12;
  localparam int PSZ_W    = 2;
  localparam int PSZ_STEP = 4;
  localparam int EPN_W    = EA_W - OFF_MIN;
  localparam int RPN_W    = RA_W - OFF_MIN;

  typedef struct packed {
    logic             vld;
    logic             as;
    logic [PID_W-1:0] pid;
    logic [EPN_W-1:0] epn;
    logic [RPN_W-1:0] rpn;
    logic [PSZ_W-1:0] psz;
  } tlb_ent_t;

  // Page-number bits that belong to the offset for a given size code
  function automatic logic [EPN_W-1:0] off_mask(input logic [PSZ_W-1:0] psz);
    logic [EPN_W-1:0] m;
    m = '0;
    for (int b = 0; b < EPN_W; b++)
      if (b < int'(psz) * PSZ_STEP) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [RA_W-1:0] make_ra(input logic [RPN_W-1:0] rpn,
                                              input logic [PSZ_W-1:0] psz,
                                              input logic [EA_W-1:0]  ea);
    logic [RPN_W-1:0] m;
    logic [RPN_W-1:0] pg;
    m  = RPN_W'(off_mask(psz));
    pg = (rpn & ~m) | (RPN_W'(ea[EA_W-1:OFF_MIN]) & m);
    return {pg, ea[OFF_MIN-1:0]};
  endfunction
endpackage

// File: rtl/utlb_match.sv
module utlb_match
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  tlb_ent_t [ENTRIES-1:0] ents,
  input  logic                   as,
  input  logic [PID_W-1:0]       pid,
  input  logic [EA_W-1:0]        ea,
  output logic                   hit,
  output logic [IDX_W-1:0]       hit_idx,
  output logic [RA_W-1:0]        hit_ra
);
  logic [ENTRIES-1:0] hitv;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitv[g] = ents[g].vld && (ents[g].as == as) && (ents[g].pid == pid) &&
                     (((ents[g].epn ^ ea[EA_W-1:OFF_MIN]) & ~off_mask(ents[g].psz)) == '0);
  end

  // Lowest index wins when overlapping pages both match
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitv[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign hit_ra = make_ra(ents[hit_idx].rpn, ents[hit_idx].psz, ea);
endmodule

// File: rtl/utlb_lru.sv
module utlb_lru #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim
);
  // rank 0 = most recent, ENTRIES-1 = least recent
  logic [IDX_W-1:0] rank_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(ENTRIES - 1 - i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)             rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[touch_idx]) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rank_q[i] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(i);
  end
endmodule

// File: rtl/utlb_l1.sv
module utlb_l1
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_all,
  input  logic             lk_valid,
  input  logic             lk_as,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [EA_W-1:0]  lk_ea,
  output logic             stall,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [RA_W-1:0]  rsp_ra,
  output logic             l2_req_valid,
  output logic             l2_req_as,
  output logic [PID_W-1:0] l2_req_pid,
  output logic [EA_W-1:0]  l2_req_ea,
  input  logic             l2_fill_valid,
  input  logic [RPN_W-1:0] l2_fill_rpn,
  input  logic [PSZ_W-1:0] l2_fill_psz
);
  tlb_ent_t [ENTRIES-1:0] ents_q;
  logic                   waiting_q;
  logic                   lk_acc, fill_acc, fill_keep;
  logic                   m_hit;
  logic [IDX_W-1:0]       m_idx, victim;
  logic [RA_W-1:0]        m_ra, fill_ra;
  logic                   touch_en;
  logic [IDX_W-1:0]       touch_idx;

  assign lk_acc    = lk_valid && !waiting_q && !inv_all;
  assign fill_acc  = l2_fill_valid && waiting_q;
  assign fill_keep = fill_acc && !inv_all;

  utlb_match #(.ENTRIES(ENTRIES)) match_i (
    .ents    (ents_q),
    .as      (lk_as),
    .pid     (lk_pid),
    .ea      (lk_ea),
    .hit     (m_hit),
    .hit_idx (m_idx),
    .hit_ra  (m_ra)
  );

  assign touch_en  = (lk_acc && m_hit) || fill_keep;
  assign touch_idx = fill_acc ? victim : m_idx;

  utlb_lru #(.ENTRIES(ENTRIES)) lru_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (inv_all),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .victim    (victim)
  );

  assign fill_ra = make_ra(l2_fill_rpn, l2_fill_psz, l2_req_ea);

  always_ff @(posedge clk) begin
    if (rst) begin
      ents_q     <= '0;
      waiting_q  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_ra     <= '0;
      l2_req_as  <= 1'b0;
      l2_req_pid <= '0;
      l2_req_ea  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (inv_all) begin
        for (int i = 0; i < ENTRIES; i++) ents_q[i].vld <= 1'b0;
      end
      if (lk_acc) begin
        if (m_hit) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_ra    <= m_ra;
        end else begin
          waiting_q  <= 1'b1;
          l2_req_as  <= lk_as;
          l2_req_pid <= lk_pid;
          l2_req_ea  <= lk_ea;
        end
      end
      if (fill_acc) begin
        waiting_q <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b0;
        rsp_ra    <= fill_ra;
      end
      if (fill_keep) begin
        ents_q[victim] <= '{vld: 1'b1, as: l2_req_as, pid: l2_req_pid,
                            epn: l2_req_ea[EA_W-1:OFF_MIN],
                            rpn: l2_fill_rpn, psz: l2_fill_psz};
      end
    end
  end

  assign stall        = waiting_q;
  assign l2_req_valid = waiting_q;
endmodule

// File: rtl/utlb_l1_chk.sv
module utlb_l1_chk (
  input logic        clk,
  input logic        rst,
  input logic        inv_all,
  input logic        lk_valid,
  input logic [31:0] lk_ea,
  input logic        stall,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [35:0] rsp_ra,
  input logic        l2_req_valid,
  input logic        l2_req_as,
  input logic [7:0]  l2_req_pid,
  input logic [31:0] l2_req_ea,
  input logic        l2_fill_valid
);
  a_r1_lookup_answered: assert property (@(posedge clk) disable iff (rst)
    lk_valid && !stall && !inv_all |=> rsp_valid || stall);

  a_r2_offset_passthru: assert property (@(posedge clk) disable iff (rst)
    lk_valid && !stall && !inv_all |=> !(rsp_valid && rsp_hit) || (rsp_ra[11:0] == $past(lk_ea[11:0])));

  a_r4_request_held: assert property (@(posedge clk) disable iff (rst)
    l2_req_valid && !l2_fill_valid |=> l2_req_valid && $stable(l2_req_ea) &&
                                       $stable(l2_req_pid) && $stable(l2_req_as));

  a_r5_quiet_while_stalled: assert property (@(posedge clk) disable iff (rst)
    stall |-> !rsp_valid);

  a_r6_fill_releases: assert property (@(posedge clk) disable iff (rst)
    stall && l2_fill_valid |=> rsp_valid && !rsp_hit && !stall);

  a_r8_inv_drops_lookup: assert property (@(posedge clk) disable iff (rst)
    inv_all && !stall |=> !rsp_valid);
endmodule

bind utlb_l1 utlb_l1_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .inv_all       (inv_all),
  .lk_valid      (lk_valid),
  .lk_ea         (lk_ea),
  .stall         (stall),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_ra        (rsp_ra),
  .l2_req_valid  (l2_req_valid),
  .l2_req_as     (l2_req_as),
  .l2_req_pid    (l2_req_pid),
  .l2_req_ea     (l2_req_ea),
  .l2_fill_valid (l2_fill_valid)
);

// File: tb/utlb_l1_tb_top.sv
module utlb_l1_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inv_all = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_as = 1'b0;
  logic [7:0]  lk_pid = '0;
  logic [31:0] lk_ea = '0;
  logic        stall, rsp_valid, rsp_hit, l2_req_valid, l2_req_as;
  logic [35:0] rsp_ra;
  logic [7:0]  l2_req_pid;
  logic [31:0] l2_req_ea;
  logic        l2_fill_valid = 1'b0;
  logic [23:0] l2_fill_rpn = '0;
  logic [1:0]  l2_fill_psz = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  utlb_l1 dut_i (
    .clk(clk), .rst(rst), .inv_all(inv_all),
    .lk_valid(lk_valid), .lk_as(lk_as), .lk_pid(lk_pid), .lk_ea(lk_ea),
    .stall(stall), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ra(rsp_ra),
    .l2_req_valid(l2_req_valid), .l2_req_as(l2_req_as),
    .l2_req_pid(l2_req_pid), .l2_req_ea(l2_req_ea),
    .l2_fill_valid(l2_fill_valid), .l2_fill_rpn(l2_fill_rpn), .l2_fill_psz(l2_fill_psz)
  );

  // Reference model: entries plus last-use stamps (smallest stamp = victim)
  logic        mv [4];
  logic        mas [4];
  logic [7:0]  mpid [4];
  logic [19:0] mepn [4];
  logic [23:0] mrpn [4];
  logic [1:0]  mpsz [4];
  int          mstamp [4];
  int          now_t;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] mask20(input logic [1:0] psz);
    return 20'((32'd1 << (4 * psz)) - 1);
  endfunction

  function automatic logic [1:0] l2_psz(input logic [31:0] ea);
    return ea[31:30];
  endfunction

  function automatic logic [23:0] l2_rpn(input logic as, input logic [7:0] pid,
                                         input logic [31:0] ea);
    logic [19:0] pg;
    pg = ea[31:12] & ~mask20(l2_psz(ea));
    return {4'b0, pg} ^ {pid, 15'd0, as} ^ 24'h9A_0000;
  endfunction

  function automatic logic [35:0] exp_ra(input logic [23:0] rpn, input logic [1:0] psz,
                                         input logic [31:0] ea);
    logic [23:0] m;
    m = {4'b0, mask20(psz)};
    return {(rpn & ~m) | ({4'b0, ea[31:12]} & m), ea[11:0]};
  endfunction

  function automatic int model_find(input logic as, input logic [7:0] pid,
                                    input logic [31:0] ea);
    for (int i = 0; i < 4; i++)
      if (mv[i] && mas[i] == as && mpid[i] == pid &&
          ((mepn[i] ^ ea[31:12]) & ~mask20(mpsz[i])) == 20'd0)
        return i;
    return -1;
  endfunction

  function automatic int model_victim();
    int v = 0;
    for (int i = 1; i < 4; i++) if (mstamp[i] < mstamp[v]) v = i;
    return v;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      mv[i] = 1'b0;
      mstamp[i] = i - 4;
    end
    now_t = 0;
  endtask

  task automatic model_touch(input int i);
    now_t++;
    mstamp[i] = now_t;
  endtask

  task automatic do_lookup(input logic as, input logic [7:0] pid, input logic [31:0] ea,
                           input int waitc, input bit poke, input string tag);
    int idx;
    int v;
    @(negedge clk);
    lk_valid = 1'b1; lk_as = as; lk_pid = pid; lk_ea = ea;
    @(negedge clk);
    lk_valid = 1'b0;
    idx = model_find(as, pid, ea);
    if (idx >= 0) begin
      chk(tag, "hit rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R1", "hit rsp_hit", 64'(rsp_hit), 64'd1);
      chk("R1", "hit stall", 64'(stall), 64'd0);
      chk("R2", "hit ra", 64'(rsp_ra), 64'(exp_ra(mrpn[idx], mpsz[idx], ea)));
      model_touch(idx);
    end else begin
      chk(tag, "miss stall", 64'(stall), 64'd1);
      chk("R4", "miss rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R4", "req_valid", 64'(l2_req_valid), 64'd1);
      chk("R4", "req fields", {23'd0, l2_req_as, l2_req_pid, l2_req_ea}, {23'd0, as, pid, ea});
      for (int k = 0; k < waitc; k++) begin
        if (poke) begin
          lk_valid = 1'b1; lk_as = ~as; lk_ea = ea ^ 32'h5000_3000;
        end
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R5", "rsp while stalled", 64'(rsp_valid), 64'd0);
        chk("R5", "req ea while stalled", 64'(l2_req_ea), 64'(ea));
        chk("R4", "stall held", 64'(stall), 64'd1);
      end
      l2_fill_valid = 1'b1;
      l2_fill_rpn = l2_rpn(as, pid, ea);
      l2_fill_psz = l2_psz(ea);
      @(negedge clk);
      l2_fill_valid = 1'b0;
      chk("R6", "fill rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R6", "fill rsp_hit", 64'(rsp_hit), 64'd0);
      chk("R6", "fill stall", 64'(stall), 64'd0);
      chk("R6", "fill ra", 64'(rsp_ra), 64'(exp_ra(l2_rpn(as, pid, ea), l2_psz(ea), ea)));
      v = model_victim();
      mv[v] = 1'b1; mas[v] = as; mpid[v] = pid; mepn[v] = ea[31:12];
      mrpn[v] = l2_rpn(as, pid, ea); mpsz[v] = l2_psz(ea);
      model_touch(v);
    end
  endtask

  task automatic do_inv(input bit with_lookup, input logic [31:0] ea);
    @(negedge clk);
    inv_all = 1'b1;
    lk_valid = with_lookup; lk_as = 1'b0; lk_pid = 8'd3; lk_ea = ea;
    @(negedge clk);
    inv_all = 1'b0; lk_valid = 1'b0;
    chk("R8", "lookup with inv dropped", 64'(rsp_valid), 64'd0);
    chk("R8", "no stall after inv", 64'(stall), 64'd0);
    model_clear();
  endtask

  initial begin
    automatic int unsigned seed = $urandom(32'd20240611);
    if (seed == 32'hFFFF_FFFF) $display("seed wrapped");
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9", "reset stall", 64'(stall), 64'd0);
    chk("R9", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R9", "reset req_valid", 64'(l2_req_valid), 64'd0);
    do_lookup(1'b0, 8'd3, 32'h0000_1234, 1, 1'b0, "R9");

    // R6: fill strobe while idle is ignored
    @(negedge clk);
    l2_fill_valid = 1'b1; l2_fill_rpn = 24'h12_3456; l2_fill_psz = 2'd3;
    @(negedge clk);
    l2_fill_valid = 1'b0;
    chk("R6", "idle fill no rsp", 64'(rsp_valid), 64'd0);
    chk("R6", "idle fill no stall", 64'(stall), 64'd0);
    do_lookup(1'b0, 8'd3, 32'h0000_5000, 0, 1'b0, "R6");

    // R3: tag fields must all match
    do_lookup(1'b1, 8'd3, 32'h0000_1000, 0, 1'b0, "R3");
    do_lookup(1'b0, 8'd7, 32'h0000_1000, 0, 1'b0, "R3");
    do_lookup(1'b0, 8'd3, 32'h0000_1FFC, 0, 1'b0, "R1");

    // R2: large page offset passthrough
    do_lookup(1'b0, 8'd3, 32'hC0AB_CDEF, 2, 1'b1, "R4");
    do_lookup(1'b0, 8'd3, 32'hC012_3456, 0, 1'b0, "R2");
    do_lookup(1'b0, 8'd3, 32'h4001_2345, 0, 1'b0, "R2");
    do_lookup(1'b0, 8'd3, 32'h4001_E000, 0, 1'b0, "R2");

    // R7: LRU after invalidate
    do_inv(1'b1, 32'h0000_1000);
    do_lookup(1'b0, 8'd3, 32'h0000_1000, 0, 1'b0, "R8");
    do_lookup(1'b0, 8'd3, 32'h0000_2000, 0, 1'b0, "R7");
    do_lookup(1'b0, 8'd3, 32'h0000_3000, 0, 1'b0, "R7");
    do_lookup(1'b0, 8'd3, 32'h0000_4000, 0, 1'b0, "R7");
    do_lookup(1'b0, 8'd3, 32'h0000_1004, 0, 1'b0, "R7");
    do_lookup(1'b0, 8'd3, 32'h0000_5000, 0, 1'b0, "R7");
    do_lookup(1'b0, 8'd3, 32'h0000_2000, 0, 1'b0, "R7");
    do_lookup(1'b0, 8'd3, 32'h0000_1008, 0, 1'b0, "R7");

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      automatic logic [31:0] ea;
      automatic logic        as = 1'($urandom_range(0, 1));
      automatic logic [7:0]  pid = ($urandom_range(0, 1) == 0) ? 8'd3 : 8'd7;
      ea = {2'($urandom_range(0, 3)), 6'd0, 8'($urandom_range(0, 1)),
            4'($urandom_range(0, 2)), 12'($urandom)};
      if ($urandom_range(0, 24) == 0) do_inv(1'($urandom_range(0, 1)), ea);
      else do_lookup(as, pid, ea, $urandom_range(0, 2), 1'($urandom_range(0, 1)), "R1");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule